// File: doc/BRIEF.md
# Single-Phase Bus Initiator Sequencer

This block is the initiator half of a 32-bit bus on which address and data share the same lines. A back-end device asks for one transfer by pulling its request line low. Along with the request it presents an address, write data, active-low byte enables, a memory-or-I/O select and a read/write select. The sequencer waits for the arbiter's grant and for the bus to go quiet. It then spends one cycle preparing and one cycle driving the address and command. After that it runs a single data phase. In the turnaround cycle it acknowledges the back-end and reports one of four outcomes: clean completion, retry, target abort, or master abort when no target claims the cycle.

Every bus output has two signals: a value and an output enable. Pad tri-stating, parity generation and parity checking are done outside this block. The block also watches the bus while it is idle. When it sees a configuration cycle addressed to its own device, it raises a configuration flag. It then stays off the bus until the back-end withdraws its request. When the arbiter parks the grant on this initiator and nothing is pending, the block keeps the address/data and command lines driven so they do not float.

The back-end must release its request in the cycle it sees the acknowledge. Otherwise the sequencer starts a new transfer.

Top module: `bus_init_seq`

## Requirements
- R1: A transfer starts from idle only when all three of these are seen at the same clock edge: `be_req_n` low, `gnt_n` low and `irdy_n_i` high.
- R2: The first bus cycle of a transfer drives FRAME high. The second drives FRAME low, drives the latched address on AD, and drives the command on C/BE.
- R3: The cycle after the address is the only data cycle. In it FRAME is driven high and IRDY is driven low. C/BE carries the byte enables. For a write, AD carries the write data. For a read, AD is not driven.
- R4: The data phase ends when DEVSEL and TRDY are low together. The next cycle is a turnaround in which `be_ack_n` is low for exactly one cycle. IRDY is driven high in that cycle and released in the cycle after. For a read, the AD value seen at completion appears on `be_rdata` during the turnaround.
- R5: A master abort occurs if DEVSEL is not low in any of the first 6 data cycles. The sequencer then leaves after the 6th data cycle and pulses `be_mabort_n` low together with `be_ack_n`. DEVSEL first seen low in the 6th data cycle still completes normally.
- R6: STOP low with DEVSEL low and TRDY high ends the phase as a retry. `be_retry_n` pulses low together with `be_ack_n`.
- R7: STOP low with DEVSEL high, after DEVSEL was low in an earlier data cycle, ends the phase as a target abort. `be_tabort_n` pulses low together with `be_ack_n`. At most one outcome line is ever low.
- R8: The command code on C/BE is 0010 for an I/O read, 0011 for an I/O write, 0110 for a memory read and 0111 for a memory write. `be_mem_sel`=1 selects memory and `be_rd`=1 selects read.
- R9: In idle, a configuration cycle for this device moves the block to a drop state. Such a cycle is FRAME low, `idsel_i` high, C/BE equal to 1010 or 1011, and AD[1:0]=00. This takes priority over starting a transfer. In the drop state `be_cfg` is high, nothing is driven and no bus request is made. The block leaves on the first edge at which `be_req_n` is high. The state is not entered if AD[1:0] is not 00 or if the command is different.
- R10: In idle, with `gnt_n` low and `be_req_n` high, AD and C/BE are driven. With `gnt_n` high they are released.
- R11: `req_n` is low while `be_req_n` is low and the sequencer is idle or in an address cycle. It is high from the first data cycle onward.
- R12: A synchronous active-low reset returns the block to idle within one edge. After that edge all output enables are off, `req_n`, `be_ack_n` and the three outcome lines are high, and `be_cfg` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| be_req_n | input | 1 | Back-end transfer request, active low |
| be_mem_sel | input | 1 | 1 = memory space, 0 = I/O space |
| be_rd | input | 1 | 1 = read, 0 = write |
| be_addr | input | 32 | Transfer address |
| be_wdata | input | 32 | Write data |
| be_byte_en_n | input | 4 | Byte enables, active low |
| be_ack_n | output | 1 | Transfer finished, one-cycle low pulse |
| be_mabort_n | output | 1 | No target responded, low with ack |
| be_retry_n | output | 1 | Target asked for retry, low with ack |
| be_tabort_n | output | 1 | Target aborted, low with ack |
| be_cfg | output | 1 | Configuration access to this device pending |
| be_rdata | output | 32 | Captured read data |
| gnt_n | input | 1 | Arbiter grant, active low |
| req_n | output | 1 | Bus request to arbiter, active low |
| frame_n_i | input | 1 | FRAME as seen on the bus |
| frame_n_o | output | 1 | FRAME value to drive |
| frame_oe | output | 1 | FRAME output enable |
| irdy_n_i | input | 1 | IRDY as seen on the bus |
| irdy_n_o | output | 1 | IRDY value to drive |
| irdy_oe | output | 1 | IRDY output enable |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| idsel_i | input | 1 | Configuration chip select |
| ad_i | input | 32 | AD as seen on the bus |
| ad_o | output | 32 | AD value to drive |
| ad_oe | output | 1 | AD output enable |
| cbe_n_i | input | 4 | C/BE as seen on the bus |
| cbe_n_o | output | 4 | C/BE value to drive |
| cbe_oe | output | 1 | C/BE output enable |

## Verification
The bench pushes DEVSEL to the edge of the abort window. A claim in the 6th data cycle must complete, while silence must abort after exactly 6 cycles. A timer that is off by one would either abort a valid target or hang one cycle too long. Target abort is produced by withdrawing DEVSEL one cycle after a claim. A sequencer that does not remember the earlier claim would report this as a master abort or a retry. The bench also presents a configuration cycle while a request and a grant are both active. A block that gives priority to starting the transfer would drive the bus during another initiator's configuration cycle. Near-miss configuration cycles must not raise the flag. Finally, the bench blocks the start with IRDY still held low by another initiator, and checks that FRAME stays undriven.

// File: rtl/bus_init_pkg.sv
// Shared types for the bus initiator sequencer.
// Assumes a 32-bit multiplexed bus with a 4-bit command/byte-enable field.
package bus_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_PREP,
        ST_ADDR_DRIVE,
        ST_DATA,
        ST_TURN,
        ST_DROP
    } seq_state_e;

    typedef enum logic [1:0] {
        OUT_DONE,
        OUT_RETRY,
        OUT_TABORT,
        OUT_MABORT
    } outcome_e;

endpackage

// File: rtl/bus_init_cmd.sv
// Command encoder: maps the space select and the direction to a 4-bit bus command.
// Assumes only single memory and I/O transfers are ever issued.
module bus_init_cmd (
    input  logic       mem_sel,
    input  logic       rd,
    output logic [3:0] cmd
);
    // Bit 2 picks memory space, bit 0 is set for writes.
    always_comb begin
        cmd = {1'b0, mem_sel, 1'b1, ~rd};
    end
endmodule

// File: rtl/bus_init_tmo.sv
// DEVSEL watchdog: counts data cycles and flags a master abort when no
// target has claimed the cycle by the last one of LIMIT data cycles.
// Assumes arm is high in the cycle before the first data cycle.
module bus_init_tmo #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    input  logic devsel_n,
    output logic seen,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Count data cycles and remember any DEVSEL claim since arming.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            if (!devsel_n)     seen_q <= 1'b1;
        end
    end

    // Abort only on the last window cycle with no claim now or before.
    always_comb begin
        seen    = seen_q;
        expired = run && !seen_q && devsel_n && (cnt_q == LAST);
    end
endmodule

// File: rtl/bus_init_snoop.sv
// Configuration snoop: recognises an address phase that is a type-0
// configuration read or write aimed at this device.
// Assumes the command field is at least 4 bits wide.
module bus_init_snoop #(
    parameter int CBE_W = 4
) (
    input  logic             frame_n,
    input  logic             idsel,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic [1:0]       ad_low,
    output logic             hit
);
    // Commands 1010 and 1011 differ only in bit 0.
    always_comb begin
        hit = !frame_n && idsel && (cbe_n[3:1] == 3'b101) && (ad_low == 2'b00);
    end
endmodule

// File: rtl/bus_init_seq.sv
// Single-phase bus initiator sequencer (top).
// Runs one address phase and one data phase per back-end request, reports
// the outcome with a one-cycle acknowledge, and yields to configuration
// cycles aimed at this device. Bus pins are value/enable pairs; parity is
// handled elsewhere. Assumes the back-end drops its request on acknowledge.
module bus_init_seq
    import bus_init_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int DEVSEL_LIMIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              be_req_n,
    input  logic              be_mem_sel,
    input  logic              be_rd,
    input  logic [DATA_W-1:0] be_addr,
    input  logic [DATA_W-1:0] be_wdata,
    input  logic [DATA_W/8-1:0] be_byte_en_n,
    output logic              be_ack_n,
    output logic              be_mabort_n,
    output logic              be_retry_n,
    output logic              be_tabort_n,
    output logic              be_cfg,
    output logic [DATA_W-1:0] be_rdata,
    input  logic              gnt_n,
    output logic              req_n,
    input  logic              frame_n_i,
    output logic              frame_n_o,
    output logic              frame_oe,
    input  logic              irdy_n_i,
    output logic              irdy_n_o,
    output logic              irdy_oe,
    input  logic              devsel_n_i,
    input  logic              trdy_n_i,
    input  logic              stop_n_i,
    input  logic              idsel_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W/8-1:0] cbe_n_i,
    output logic [DATA_W/8-1:0] cbe_n_o,
    output logic              cbe_oe
);
    localparam int CBE_W = DATA_W / 8;

    seq_state_e        state_q, state_d;
    outcome_e          outcome_q, outcome_d;
    logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
    logic [CBE_W-1:0]  be_q, cmd_q;
    logic              rd_q;
    logic [3:0]        cmd_w;
    logic              snoop_hit, start, launch, phase_end;
    logic              devsel_seen, tmo_expired, in_data;

    bus_init_cmd u_cmd (
        .mem_sel (be_mem_sel),
        .rd      (be_rd),
        .cmd     (cmd_w)
    );

    bus_init_snoop #(.CBE_W(CBE_W)) u_snoop (
        .frame_n (frame_n_i),
        .idsel   (idsel_i),
        .cbe_n   (cbe_n_i),
        .ad_low  (ad_i[1:0]),
        .hit     (snoop_hit)
    );

    bus_init_tmo #(.LIMIT(DEVSEL_LIMIT)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state_q == ST_ADDR_DRIVE),
        .run      (in_data),
        .devsel_n (devsel_n_i),
        .seen     (devsel_seen),
        .expired  (tmo_expired)
    );

    // Start and launch qualifiers.
    always_comb begin
        in_data = (state_q == ST_DATA);
        start   = !be_req_n && !gnt_n && irdy_n_i;
        launch  = (state_q == ST_IDLE) && !snoop_hit && start;
    end

    // Decide how a data cycle ends: completion, retry, target abort, timeout.
    always_comb begin
        phase_end = 1'b0;
        outcome_d = OUT_DONE;
        if (!devsel_n_i && !trdy_n_i) begin
            phase_end = 1'b1;
            outcome_d = OUT_DONE;
        end else if (!stop_n_i && !devsel_n_i) begin
            phase_end = 1'b1;
            outcome_d = OUT_RETRY;
        end else if (!stop_n_i && devsel_seen) begin
            phase_end = 1'b1;
            outcome_d = OUT_TABORT;
        end else if (tmo_expired) begin
            phase_end = 1'b1;
            outcome_d = OUT_MABORT;
        end
    end

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (snoop_hit)  state_d = ST_DROP;
                else if (start) state_d = ST_ADDR_PREP;
            end
            ST_ADDR_PREP:  state_d = ST_ADDR_DRIVE;
            ST_ADDR_DRIVE: state_d = ST_DATA;
            ST_DATA:       if (phase_end) state_d = ST_TURN;
            ST_TURN:       state_d = ST_IDLE;
            ST_DROP:       if (be_req_n) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the back-end request at launch so the bus sees stable values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            cmd_q   <= '0;
            rd_q    <= 1'b0;
        end else if (launch) begin
            addr_q  <= be_addr;
            wdata_q <= be_wdata;
            be_q    <= be_byte_en_n;
            cmd_q   <= CBE_W'(cmd_w);
            rd_q    <= be_rd;
        end
    end

    // Record the outcome and read data when the data phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome_q <= OUT_DONE;
            rdata_q   <= '0;
        end else if (in_data && phase_end) begin
            outcome_q <= outcome_d;
            if (rd_q && outcome_d == OUT_DONE) rdata_q <= ad_i;
        end
    end

    // Drive bus and back-end outputs from the current state.
    always_comb begin
        frame_oe    = 1'b0;
        frame_n_o   = 1'b1;
        irdy_oe     = 1'b0;
        irdy_n_o    = 1'b1;
        ad_oe       = 1'b0;
        ad_o        = '0;
        cbe_oe      = 1'b0;
        cbe_n_o     = '0;
        be_ack_n    = 1'b1;
        be_mabort_n = 1'b1;
        be_retry_n  = 1'b1;
        be_tabort_n = 1'b1;
        be_cfg      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                ad_oe  = !gnt_n && be_req_n;
                cbe_oe = !gnt_n && be_req_n;
            end
            ST_ADDR_PREP: begin
                frame_oe = 1'b1;
                irdy_oe  = 1'b1;
                ad_oe    = 1'b1;
                cbe_oe   = 1'b1;
            end
            ST_ADDR_DRIVE: begin
                frame_oe  = 1'b1;
                frame_n_o = 1'b0;
                irdy_oe   = 1'b1;
                ad_oe     = 1'b1;
                ad_o      = addr_q;
                cbe_oe    = 1'b1;
                cbe_n_o   = cmd_q;
            end
            ST_DATA: begin
                frame_oe = 1'b1;
                irdy_oe  = 1'b1;
                irdy_n_o = 1'b0;
                ad_oe    = !rd_q;
                ad_o     = wdata_q;
                cbe_oe   = 1'b1;
                cbe_n_o  = be_q;
            end
            ST_TURN: begin
                irdy_oe     = 1'b1;
                be_ack_n    = 1'b0;
                be_mabort_n = (outcome_q != OUT_MABORT);
                be_retry_n  = (outcome_q != OUT_RETRY);
                be_tabort_n = (outcome_q != OUT_TABORT);
            end
            ST_DROP: be_cfg = 1'b1;
            default: ;
        endcase
    end

    // Bus request follows the back-end until the address has gone out.
    always_comb begin
        req_n = !(!be_req_n && (state_q == ST_IDLE || state_q == ST_ADDR_PREP ||
                                state_q == ST_ADDR_DRIVE));
        be_rdata = rdata_q;
    end
endmodule

// File: rtl/bus_init_seq_chk.sv
// Protocol checker for bus_init_seq, attached by bind. Observes ports only.
module bus_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic be_req_n,
    input logic gnt_n,
    input logic irdy_n_i,
    input logic be_ack_n,
    input logic be_mabort_n,
    input logic be_retry_n,
    input logic be_tabort_n,
    input logic be_cfg,
    input logic req_n,
    input logic frame_n_o,
    input logic frame_oe,
    input logic irdy_n_o,
    input logic irdy_oe,
    input logic ad_oe,
    input logic cbe_oe
);
    p_start_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_oe) |-> $past(!be_req_n && !gnt_n && irdy_n_i));

    p_prep_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_oe) |-> frame_n_o);

    p_addr_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_oe) |=> (frame_oe && !frame_n_o));

    p_single_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_oe && !frame_n_o) |=> (frame_oe && frame_n_o && irdy_oe && !irdy_n_o));

    p_irdy_high_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irdy_oe) |-> $past(irdy_n_o));

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !be_ack_n |=> be_ack_n);

    p_outcome_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!be_mabort_n || !be_retry_n || !be_tabort_n) |->
        (!be_ack_n && $countones({!be_mabort_n, !be_retry_n, !be_tabort_n}) == 1));

    p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        be_cfg |-> (!frame_oe && !ad_oe && !cbe_oe && req_n));

    p_req_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_oe && !frame_n_o) |=> req_n);
endmodule

bind bus_init_seq bus_init_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .be_req_n    (be_req_n),
    .gnt_n       (gnt_n),
    .irdy_n_i    (irdy_n_i),
    .be_ack_n    (be_ack_n),
    .be_mabort_n (be_mabort_n),
    .be_retry_n  (be_retry_n),
    .be_tabort_n (be_tabort_n),
    .be_cfg      (be_cfg),
    .req_n       (req_n),
    .frame_n_o   (frame_n_o),
    .frame_oe    (frame_oe),
    .irdy_n_o    (irdy_n_o),
    .irdy_oe     (irdy_oe),
    .ad_oe       (ad_oe),
    .cbe_oe      (cbe_oe)
);

// File: tb/bus_init_seq_bench.sv
// Bench for bus_init_seq: a vector table of transfers against a modelled
// target, then directed tests for reset, start guard, parking and snoop.
module bus_init_seq_bench;

    localparam logic [1:0] RSP_OK = 2'd0, RSP_RETRY = 2'd1, RSP_TABORT = 2'd2, RSP_NONE = 2'd3;

    typedef struct packed {
        logic        mem;
        logic        rd;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [1:0]  resp;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 32'h1000_0040, 32'hA5A5_0F0F, 4'b0000, RSP_OK,     4'd1},
        '{1'b0, 1'b1, 32'h0000_0310, 32'h1234_5678, 4'b1100, RSP_OK,     4'd3},
        '{1'b1, 1'b1, 32'h8000_0000, 32'hDEAD_BEEF, 4'b0000, RSP_OK,     4'd6},
        '{1'b0, 1'b0, 32'h0000_0420, 32'h0000_00FF, 4'b1110, RSP_RETRY,  4'd2},
        '{1'b1, 1'b0, 32'h2000_1000, 32'hCAFE_F00D, 4'b0011, RSP_TABORT, 4'd1},
        '{1'b1, 1'b1, 32'h3000_0008, 32'h0BAD_0BAD, 4'b0000, RSP_NONE,   4'd0},
        '{1'b0, 1'b0, 32'h0000_0500, 32'h5555_AAAA, 4'b1110, RSP_OK,     4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        be_req_n, be_mem_sel, be_rd;
    logic [31:0] be_addr, be_wdata;
    logic [3:0]  be_byte_en_n;
    logic        be_ack_n, be_mabort_n, be_retry_n, be_tabort_n, be_cfg;
    logic [31:0] be_rdata;
    logic        gnt_n, req_n;
    logic        frame_n_o, frame_oe, irdy_n_o, irdy_oe;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic [3:0]  cbe_n_o;
    logic        cbe_oe;
    logic        tb_frame_n, tb_irdy_n, tb_devsel_n, tb_trdy_n, tb_stop_n, tb_idsel;
    logic [31:0] tb_ad;
    logic [3:0]  tb_cbe_n;
    logic        frame_n_i, irdy_n_i;
    logic [31:0] ad_i;
    logic [3:0]  cbe_n_i;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    // Resolved bus: the design's driver wins when enabled.
    assign frame_n_i = frame_oe ? frame_n_o : tb_frame_n;
    assign irdy_n_i  = irdy_oe  ? irdy_n_o  : tb_irdy_n;
    assign ad_i      = ad_oe    ? ad_o      : tb_ad;
    assign cbe_n_i   = cbe_oe   ? cbe_n_o   : tb_cbe_n;

    bus_init_seq u_bus_init_seq (
        .clk(clk), .rst_n(rst_n),
        .be_req_n(be_req_n), .be_mem_sel(be_mem_sel), .be_rd(be_rd),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_byte_en_n(be_byte_en_n),
        .be_ack_n(be_ack_n), .be_mabort_n(be_mabort_n), .be_retry_n(be_retry_n),
        .be_tabort_n(be_tabort_n), .be_cfg(be_cfg), .be_rdata(be_rdata),
        .gnt_n(gnt_n), .req_n(req_n),
        .frame_n_i(frame_n_i), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
        .irdy_n_i(irdy_n_i), .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe),
        .devsel_n_i(tb_devsel_n), .trdy_n_i(tb_trdy_n), .stop_n_i(tb_stop_n),
        .idsel_i(tb_idsel),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .cbe_n_i(cbe_n_i), .cbe_n_o(cbe_n_o), .cbe_oe(cbe_oe)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    // Command codes taken from the requirement table (R8).
    function automatic logic [3:0] cmd_of(input logic mem, input logic rd);
        case ({mem, rd})
            2'b00:   return 4'b0011;
            2'b01:   return 4'b0010;
            2'b10:   return 4'b0111;
            default: return 4'b0110;
        endcase
    endfunction

    task automatic release_target();
        tb_devsel_n = 1'b1;
        tb_trdy_n   = 1'b1;
        tb_stop_n   = 1'b1;
        tb_ad       = 32'h0;
    endtask

    task automatic run_vec(input vec_t v);
        int       k;
        bit       saw_prep;
        bit       finished;
        int       exp_k;
        logic [2:0] exp_st;
        string    rq;
        k = 0; saw_prep = 0; finished = 0;
        case (v.resp)
            RSP_OK:     begin exp_k = v.dly;     exp_st = 3'b000; rq = "R4"; end
            RSP_RETRY:  begin exp_k = v.dly;     exp_st = 3'b010; rq = "R6"; end
            RSP_TABORT: begin exp_k = v.dly + 1; exp_st = 3'b001; rq = "R7"; end
            default:    begin exp_k = 6;         exp_st = 3'b100; rq = "R5"; end
        endcase
        be_mem_sel = v.mem; be_rd = v.rd; be_addr = v.addr; be_wdata = v.data;
        be_byte_en_n = v.be; be_req_n = 1'b0; gnt_n = 1'b0;
        for (int c = 0; c < 60 && !finished; c++) begin
            @(negedge clk);
            if (frame_oe && frame_n_o && irdy_oe && irdy_n_o) begin
                saw_prep = 1;
            end else if (frame_oe && !frame_n_o) begin
                check(saw_prep && ad_oe && ad_o == v.addr, "R2", "address phase AD", ad_o, v.addr);
                check(cbe_oe && cbe_n_o == cmd_of(v.mem, v.rd), "R8", "command code",
                      {28'h0, cbe_n_o}, {28'h0, cmd_of(v.mem, v.rd)});
                check(req_n == 1'b0, "R11", "request held in address", {31'h0, req_n}, 32'h0);
                gnt_n = 1'b1;
            end else if (irdy_oe && !irdy_n_o) begin
                k++;
                if (k == 1) begin
                    check(frame_oe && frame_n_o, "R3", "FRAME high in data", {31'h0, frame_n_o}, 32'h1);
                    if (v.rd) check(!ad_oe, "R3", "AD released on read", {31'h0, ad_oe}, 32'h0);
                    else      check(ad_oe && ad_o == v.data, "R3", "write data", ad_o, v.data);
                    check(cbe_oe && cbe_n_o == v.be, "R3", "byte enables", {28'h0, cbe_n_o}, {28'h0, v.be});
                    check(req_n == 1'b1, "R11", "request dropped in data", {31'h0, req_n}, 32'h1);
                end
                case (v.resp)
                    RSP_OK: if (k >= int'(v.dly)) begin
                        tb_devsel_n = 1'b0; tb_trdy_n = 1'b0; tb_ad = v.data;
                    end
                    RSP_RETRY: if (k >= int'(v.dly)) begin
                        tb_devsel_n = 1'b0; tb_stop_n = 1'b0;
                    end
                    RSP_TABORT: begin
                        if (k == int'(v.dly)) tb_devsel_n = 1'b0;
                        else if (k > int'(v.dly)) begin tb_devsel_n = 1'b1; tb_stop_n = 1'b0; end
                    end
                    default: ;
                endcase
            end else if (!be_ack_n) begin
                check({!be_mabort_n, !be_retry_n, !be_tabort_n} == exp_st, rq, "outcome lines",
                      {29'h0, !be_mabort_n, !be_retry_n, !be_tabort_n}, {29'h0, exp_st});
                check(k == exp_k, rq, "data cycle count", k, exp_k);
                check(irdy_oe && irdy_n_o, "R4", "IRDY driven high in turnaround", {31'h0, irdy_n_o}, 32'h1);
                if (v.rd && v.resp == RSP_OK)
                    check(be_rdata == v.data, "R4", "read data", be_rdata, v.data);
                be_req_n = 1'b1;
                release_target();
                finished = 1;
            end
        end
        if (!finished) check(1'b0, rq, "no acknowledge", 32'h0, 32'h1);
        @(negedge clk);
        check(be_ack_n && !irdy_oe && !frame_oe, "R4", "ack single and IRDY released",
              {29'h0, be_ack_n, irdy_oe, frame_oe}, 32'h4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; be_req_n = 1'b1; be_mem_sel = 1'b0; be_rd = 1'b0;
        be_addr = '0; be_wdata = '0; be_byte_en_n = '0; gnt_n = 1'b1;
        tb_frame_n = 1'b1; tb_irdy_n = 1'b1; tb_idsel = 1'b0; tb_cbe_n = 4'hF;
        release_target();
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe, "R12", "enables off in reset",
              {28'h0, frame_oe, irdy_oe, ad_oe, cbe_oe}, 32'h0);
        check(req_n && be_ack_n && be_mabort_n && be_retry_n && be_tabort_n && !be_cfg,
              "R12", "handshake idle in reset",
              {26'h0, req_n, be_ack_n, be_mabort_n, be_retry_n, be_tabort_n, be_cfg}, 32'h3E);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2..R8, R11 with several target behaviours.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: IRDY still held by another initiator blocks the start.
        tb_irdy_n = 1'b0; be_req_n = 1'b0; gnt_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!frame_oe && !irdy_oe, "R1", "no start while IRDY low",
              {30'h0, frame_oe, irdy_oe}, 32'h0);
        check(req_n == 1'b0, "R11", "request follows back-end", {31'h0, req_n}, 32'h0);
        // R1: no grant blocks the start.
        tb_irdy_n = 1'b1; gnt_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!frame_oe, "R1", "no start without grant", {31'h0, frame_oe}, 32'h0);
        be_req_n = 1'b1;
        @(negedge clk);

        // R10: parked grant drives AD and C/BE, removed grant releases them.
        gnt_n = 1'b0;
        @(negedge clk);
        check(ad_oe && cbe_oe, "R10", "parked bus driven", {30'h0, ad_oe, cbe_oe}, 32'h3);
        gnt_n = 1'b1;
        @(negedge clk);
        check(!ad_oe && !cbe_oe, "R10", "bus released without grant", {30'h0, ad_oe, cbe_oe}, 32'h0);

        // R9: configuration cycle wins over a ready start.
        tb_frame_n = 1'b0; tb_idsel = 1'b1; tb_cbe_n = 4'b1010; tb_ad = 32'h0000_0010;
        be_req_n = 1'b0; gnt_n = 1'b0;
        @(negedge clk);
        check(be_cfg && !frame_oe && !ad_oe && req_n, "R9", "drop state entered",
              {28'h0, be_cfg, frame_oe, ad_oe, req_n}, 32'h9);
        tb_frame_n = 1'b1; tb_idsel = 1'b0; tb_cbe_n = 4'hF; tb_ad = '0;
        repeat (3) @(negedge clk);
        check(be_cfg && !frame_oe && req_n, "R9", "drop held while request low",
              {29'h0, be_cfg, frame_oe, req_n}, 32'h5);
        be_req_n = 1'b1; gnt_n = 1'b1;
        @(negedge clk);
        check(!be_cfg, "R9", "drop left on request release", {31'h0, be_cfg}, 32'h0);
        // R9: near misses do not trigger.
        tb_frame_n = 1'b0; tb_idsel = 1'b1; tb_cbe_n = 4'b1011; tb_ad = 32'h0000_0011;
        @(negedge clk);
        check(!be_cfg, "R9", "AD[1:0]=01 ignored", {31'h0, be_cfg}, 32'h0);
        tb_cbe_n = 4'b0110; tb_ad = 32'h0000_0010;
        @(negedge clk);
        check(!be_cfg, "R9", "memory command ignored", {31'h0, be_cfg}, 32'h0);
        tb_frame_n = 1'b1; tb_idsel = 1'b0; tb_cbe_n = 4'hF; tb_ad = '0;
        @(negedge clk);

        // R12: reset in the middle of a transfer.
        be_mem_sel = 1'b1; be_rd = 1'b0; be_req_n = 1'b0; gnt_n = 1'b0;
        repeat (2) @(negedge clk);
        check(frame_oe && !frame_n_o, "R2", "address phase before reset", {31'h0, frame_n_o}, 32'h0);
        rst_n = 1'b0; be_req_n = 1'b1; gnt_n = 1'b1;
        @(negedge clk);
        check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe && req_n && be_ack_n, "R12",
              "mid-transfer reset", {26'h0, frame_oe, irdy_oe, ad_oe, cbe_oe, req_n, be_ack_n}, 32'h3);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule